// File: doc/BRIEF.md
# Serial Receive Break Detector

This block monitors a serial receive line and reports break conditions. Break is the line held low for a whole character frame. In asynchronous mode a strobe arrives sixteen times per bit period. The block finds the falling start edge, confirms it near the middle of the start bit, and then takes one sample per bit at that phase. In synchronous mode every strobe is one bit sample.

A frame whose data bits, optional parity bit and stop bit are all sampled low is a break. The block sets a sticky status flag at the stop sample and enters a break state. In that state no new start bit is accepted. The break ends when the line is seen high on a short run of consecutive strobes: two strobes in asynchronous mode, one in synchronous mode. The flag is set again at that point, so software sees both edges of the break.

The flag stays set until a clear pulse arrives. An interrupt output follows the flag, gated by a mask input. A frame that ends with a low stop bit after non-zero data is not a break. It raises a one-cycle framing-error pulse instead.

Top module: `brk_det`

## Requirements
- R1: When the start bit, all data bits, the parity bit (when `parity_en_i`=1) and the stop bit are sampled low, `brk_flag_o` and `in_break_o` go high on the clock edge of the stop sample, and not before it.
- R2: A low stop bit that follows data with at least one bit sampled high gives a one-cycle `frm_err_o` pulse, leaves `brk_flag_o` unchanged and does not enter the break state.
- R3: In asynchronous mode (`sync_mode_i`=0) the break ends only after two consecutive strobes with the line high. A single high strobe followed by a low strobe does not end it.
- R4: In synchronous mode (`sync_mode_i`=1) the break ends on the first strobe with the line high.
- R5: At the end of a break `in_break_o` falls and `brk_flag_o` is set again, on the same clock edge.
- R6: `brk_flag_o` holds until a `clr_i` pulse clears it. A set event in the same cycle as `clr_i` wins, and the flag stays high.
- R7: `irq_o` is high exactly when `brk_flag_o` and `mask_i` are both high.
- R8: While `in_break_o` is high, a low line is never taken as a start bit. The break state holds, and no `frm_err_o` pulse appears however long the line stays low.
- R9: A frame has 5 + `data_len_i` data bits (codes 0..3 give 5..8 bits), sent LSB first. One parity bit follows when `parity_en_i`=1, and then one stop bit.
- R10: While `rx_en_i`=0 the receiver returns to idle and `in_break_o` goes low on the next edge. `brk_flag_o` keeps its value.
- R11: A frame with a high stop bit produces neither a flag nor a framing-error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| rx_i | input | 1 | Serial receive line |
| tick_i | input | 1 | Sample strobe: 16 per bit in asynchronous mode, 1 per bit in synchronous mode |
| sync_mode_i | input | 1 | 1 = synchronous, 0 = asynchronous 16x |
| data_len_i | input | 2 | Data length code, bits = 5 + code |
| parity_en_i | input | 1 | A parity bit is present in the frame |
| clr_i | input | 1 | Status clear pulse |
| mask_i | input | 1 | Interrupt mask, 1 = enabled |
| brk_flag_o | output | 1 | Sticky break status (set at break start and at break end) |
| irq_o | output | 1 | Interrupt request |
| in_break_o | output | 1 | Receiver is inside a break |
| frm_err_o | output | 1 | One-cycle framing-error pulse |

## Verification
The bench sweeps every data length, parity setting and mode. It checks that the flag is still clear just before the stop sample and set right after it. A design that counts the wrong number of bits, or ignores the parity slot, would flag too early or miss the break. In asynchronous mode the bench sends a lone high strobe inside a break, then a pair. A detector that ends on one high sample, or does not restart its count on a low strobe, would leave the break early. Long low stretches inside a break would expose a receiver that re-arms on the next start bit and reports a framing error. A clear that lands on the end-of-break strobe shows whether set really takes priority over clear.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_st_e;
endpackage

// File: rtl/brk_bitclk.sv
// Bit-phase counter; OVS must be a power of two.
module brk_bitclk #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sync_mode_i,
  input  logic restart_i,
  output logic samp_o
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] SAMP_PH = PH_W'(OVS / 2 - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (restart_i) ph_q <= '0;
    else if (tick_i)    ph_q <= ph_q + 1'b1;
  end

  assign samp_o = tick_i & (sync_mode_i | (ph_q == SAMP_PH));
endmodule

// File: rtl/brk_end.sv
module brk_end #(
  parameter int END_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic rx_i,
  input  logic sync_mode_i,
  output logic end_o
);
  localparam int W = $clog2(END_TICKS + 1);

  logic [W-1:0] hi_q, hi_nx, need;

  assign hi_nx = hi_q + 1'b1;
  assign need  = sync_mode_i ? W'(1) : W'(END_TICKS);
  assign end_o = active_i & tick_i & rx_i & (hi_nx >= need);

  // consecutive high strobes; a low strobe restarts the run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_q <= '0;
    else if (!active_i) hi_q <= '0;
    else if (tick_i)    hi_q <= rx_i ? hi_nx : '0;
  end
endmodule

// File: rtl/brk_frame.sv
module brk_frame
  import brk_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             rx_i,
  input  logic             tick_i,
  input  logic             samp_i,
  input  logic             sync_mode_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic             parity_en_i,
  input  logic             end_i,
  output logic             restart_o,
  output logic             brk_o,
  output logic             frm_err_o,
  output logic             in_break_o
);
  localparam int MAX_BITS = MIN_BITS + (1 << LEN_W) - 1;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  rx_st_e           st_q, st_d;
  logic [CNT_W-1:0] bit_q, bit_d, last_idx;
  logic             zero_q, zero_d;

  assign last_idx   = CNT_W'(MIN_BITS) + CNT_W'(data_len_i) - 1'b1;
  assign restart_o  = (st_q == ST_IDLE) & rx_en_i & tick_i & ~rx_i;
  assign in_break_o = (st_q == ST_BRK);

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    zero_d    = zero_q;
    brk_o     = 1'b0;
    frm_err_o = 1'b0;
    if (!rx_en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (restart_o) begin
          st_d   = sync_mode_i ? ST_DATA : ST_START;
          bit_d  = '0;
          zero_d = 1'b1;
        end
        ST_START: if (samp_i) st_d = rx_i ? ST_IDLE : ST_DATA;
        ST_DATA: if (samp_i) begin
          zero_d = zero_q & ~rx_i;
          if (bit_q == last_idx) st_d = parity_en_i ? ST_PAR : ST_STOP;
          else                   bit_d = bit_q + 1'b1;
        end
        ST_PAR: if (samp_i) begin
          zero_d = zero_q & ~rx_i;
          st_d   = ST_STOP;
        end
        ST_STOP: if (samp_i) begin
          if (rx_i) begin
            st_d = ST_IDLE;
          end else if (zero_q) begin
            brk_o = 1'b1;
            st_d  = ST_BRK;
          end else begin
            frm_err_o = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_BRK: if (end_i) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      zero_q <= zero_d;
    end
  end
endmodule

// File: rtl/brk_flag.sv
module brk_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o & mask_i;
endmodule

// File: rtl/brk_det.sv
module brk_det #(
  parameter int OVS       = 16,
  parameter int END_TICKS = 2,
  parameter int MIN_BITS  = 5,
  parameter int LEN_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             rx_i,
  input  logic             tick_i,
  input  logic             sync_mode_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic             parity_en_i,
  input  logic             clr_i,
  input  logic             mask_i,
  output logic             brk_flag_o,
  output logic             irq_o,
  output logic             in_break_o,
  output logic             frm_err_o
);
  logic restart, samp, brk_start, brk_end_w;

  brk_bitclk #(.OVS(OVS)) u_bitclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .sync_mode_i (sync_mode_i),
    .restart_i   (restart),
    .samp_o      (samp)
  );

  brk_frame #(.MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_en_i     (rx_en_i),
    .rx_i        (rx_i),
    .tick_i      (tick_i),
    .samp_i      (samp),
    .sync_mode_i (sync_mode_i),
    .data_len_i  (data_len_i),
    .parity_en_i (parity_en_i),
    .end_i       (brk_end_w),
    .restart_o   (restart),
    .brk_o       (brk_start),
    .frm_err_o   (frm_err_o),
    .in_break_o  (in_break_o)
  );

  brk_end #(.END_TICKS(END_TICKS)) u_end (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (in_break_o & rx_en_i),
    .tick_i      (tick_i),
    .rx_i        (rx_i),
    .sync_mode_i (sync_mode_i),
    .end_o       (brk_end_w)
  );

  brk_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (brk_start | brk_end_w),
    .clr_i  (clr_i),
    .mask_i (mask_i),
    .flag_o (brk_flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/brk_det_chk.sv
module brk_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic rx_i,
  input logic tick_i,
  input logic sync_mode_i,
  input logic clr_i,
  input logic brk_flag_o,
  input logic in_break_o,
  input logic frm_err_o
);
  a_r1_flag_at_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_break_o) |-> brk_flag_o && !frm_err_o);

  a_r2_frm_no_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o |=> !in_break_o);

  a_r4_sync_one_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_break_o && rx_en_i && sync_mode_i && tick_i && rx_i |=> !in_break_o && brk_flag_o);

  a_r5_flag_at_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_break_o) && $past(rx_en_i) |-> brk_flag_o);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_flag_o && !clr_i |=> brk_flag_o);

  a_r8_low_holds_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_break_o && rx_en_i && !(tick_i && rx_i) |=> in_break_o && !frm_err_o);

  a_r10_disable_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !in_break_o);
endmodule

bind brk_det brk_det_chk u_chk (.*);

// File: tb/tb_brk_det.sv
module tb_brk_det;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       sync_mode_i = 1'b0;
  logic [1:0] data_len_i = '0;
  logic       parity_en_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       mask_i = 1'b0;
  logic       brk_flag_o, irq_o, in_break_o, frm_err_o;

  int n_vec = 0;
  int n_bad = 0;
  int frm_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  brk_det dut (.*);

  always @(posedge clk_i) if (frm_err_o) frm_cnt <= frm_cnt + 1;

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (mode %0d len %0d par %0d)",
               req, act, exp, sync_mode_i, data_len_i, parity_en_i);
    end
  endtask

  task automatic do_tick(input logic v, input logic c);
    @(negedge clk_i);
    rx_i = v; tick_i = 1'b1; clr_i = c;
    @(negedge clk_i);
    tick_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic send_bit(input logic v);
    if (sync_mode_i) do_tick(v, 1'b0);
    else repeat (16) do_tick(v, 1'b0);
  endtask

  // start bit, data LSB first, optional parity bit; stop bit sent separately
  task automatic send_head(input logic [7:0] d, input logic pb);
    send_bit(1'b0);
    for (int i = 0; i < 5 + int'(data_len_i); i++) send_bit(d[i]);
    if (parity_en_i) send_bit(pb);
  endtask

  task automatic pulse_clr();
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk_i);
    chk("reset flag", brk_flag_o, 1'b0);
    chk("reset irq", irq_o, 1'b0);
    chk("reset in_break", in_break_o, 1'b0);
    rst_ni = 1'b1;
    rx_en_i = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 2; p++) begin
          sync_mode_i = m[0]; data_len_i = l[1:0]; parity_en_i = p[0];
          mask_i = l[0];
          repeat (2) send_bit(1'b1);
          pulse_clr();
          // R11: normal frame
          f0 = frm_cnt;
          send_head(8'h15, 1'b1); send_bit(1'b1);
          chk("R11 flag", brk_flag_o, 1'b0);
          chk("R11 frm", frm_cnt != f0, 1'b0);
          // R2: low stop after non-zero data (only the MSB data bit high)
          f0 = frm_cnt;
          send_head(8'h01 << (4 + l), 1'b0); send_bit(1'b0);
          chk("R2 frm", frm_cnt == f0 + 1, 1'b1);
          chk("R2 flag", brk_flag_o, 1'b0);
          chk("R2 in_break", in_break_o, 1'b0);
          repeat (2) send_bit(1'b1);
          // R1/R9: break, flag only after stop sample
          send_head(8'h00, 1'b0);
          chk("R1 R9 early flag", brk_flag_o, 1'b0);
          send_bit(1'b0);
          chk("R1 R9 flag", brk_flag_o, 1'b1);
          chk("R1 in_break", in_break_o, 1'b1);
          chk("R7 irq", irq_o, mask_i);
          // R6: clear
          pulse_clr();
          chk("R6 clear", brk_flag_o, 1'b0);
          chk("R7 irq clear", irq_o, 1'b0);
          // R8: long low inside break
          f0 = frm_cnt;
          repeat (3) send_bit(1'b0);
          chk("R8 in_break", in_break_o, 1'b1);
          chk("R8 frm", frm_cnt != f0, 1'b0);
          chk("R8 flag", brk_flag_o, 1'b0);
          if (!sync_mode_i) begin
            do_tick(1'b1, 1'b0);
            chk("R3 one high", in_break_o, 1'b1);
            do_tick(1'b0, 1'b0);
            do_tick(1'b1, 1'b0);
            chk("R3 run restarted", in_break_o, 1'b1);
            do_tick(1'b1, 1'b0);
            chk("R3 two high", in_break_o, 1'b0);
            chk("R5 flag async", brk_flag_o, 1'b1);
          end else begin
            do_tick(1'b1, 1'b1); // clr on the ending strobe
            chk("R4 one high", in_break_o, 1'b0);
            chk("R5 R6 set over clr", brk_flag_o, 1'b1);
          end
          chk("R7 irq end", irq_o, mask_i);
        end
    // R10: disable inside break
    sync_mode_i = 1'b1; data_len_i = 2'd0; parity_en_i = 1'b0;
    pulse_clr();
    send_head(8'h00, 1'b0); send_bit(1'b0);
    pulse_clr();
    chk("R10 pre", in_break_o, 1'b1);
    @(negedge clk_i); rx_en_i = 1'b0;
    @(negedge clk_i); rx_en_i = 1'b1;
    chk("R10 exit", in_break_o, 1'b0);
    chk("R10 flag kept", brk_flag_o, 1'b0);
    pulse_clr();
    send_head(8'h00, 1'b0); send_bit(1'b0);
    @(negedge clk_i); rx_en_i = 1'b0;
    @(negedge clk_i); rx_en_i = 1'b1;
    chk("R10 flag held", brk_flag_o, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule